// File: doc/BRIEF.md
# Parallel FPGA Configuration Master

This block drives an FPGA's 8-bit parallel slave configuration port from inside a larger chip. A load starts from a command that carries a byte count. The block pulses the device's program request and waits until the device reports that it is ready. It then streams bytes from an upstream valid/ready source onto the data bus, one byte per rising edge of the configuration clock. After the last byte it keeps clocking until the device reports that it is done. Readback is a separate command. It clocks bytes out of the device and presents each one downstream as a single-cycle valid pulse.

Every configuration clock phase lasts `HALF_CYC` system clocks. At a 250 MHz system clock, the default of 3 keeps the configuration clock under 50 MHz. When `CHECK_BUSY` is set, the device's busy flag is sampled at the end of every high phase. While it is high, the block repeats clock pulses and holds the same byte on the bus. Three waits are covered by a `TMO_CYC` watchdog: the ready wait, a busy stall and the done wait. When the watchdog expires, the block leaves the device pins quiet and latches an abort status.

All pin-side signals are active high at this boundary. Pad polarity is handled outside the block. `cfg_init_i` high means the device is ready, `cfg_busy_i` high means busy, and `cfg_done_i` high means configuration is complete.

Top module: `fpga_cfg_master`

## Requirements
- R1: After reset, cfg_prog_o, cfg_cs_o, cfg_wr_o, cfg_dq_oe_o, act_o, ok_o and abort_o are 0 and cfg_cclk_o is 1.
- R2: A start with rb_mode_i=0 raises cfg_prog_o for exactly HALF_CYC cycles. cfg_cs_o and cfg_wr_o stay low until the block samples cfg_init_i=1 together with cfg_busy_i=0.
- R3: Once the device is ready, cfg_cs_o and cfg_wr_o are raised with cfg_cclk_o high before the first byte is driven. src_ready_o is high only while the block waits for the next byte.
- R4: Each accepted byte appears on cfg_dq_o with cfg_dq_oe_o=1 in the same cycle that cfg_cclk_o falls. The byte stays unchanged through the following rising edge. Every low phase lasts exactly HALF_CYC cycles. The device sees the bytes in order, one per rising edge.
- R5: With CHECK_BUSY=1, if cfg_busy_i is 1 at the end of a high phase, further clock pulses are issued with the same byte held until cfg_busy_i is seen at 0.
- R6: After the last byte, cfg_cs_o falls first. cfg_wr_o stays high for one more phase, and the bus is released. Clock pulses then continue until cfg_done_i=1 is seen at the end of a high phase. ok_o then rises and is never high together with abort_o.
- R7: If the ready wait, a busy stall or the done wait lasts TMO_CYC cycles, the block returns to idle with cfg_cs_o, cfg_wr_o and cfg_dq_oe_o at 0, and abort_o latched at 1.
- R8: A start with rb_mode_i=1 raises cfg_cs_o with cfg_wr_o=0 and the bus released. Each byte takes a low phase and then a high phase. cfg_dq_i is sampled at the end of the high phase and shown on snk_data_o with a one-cycle snk_valid_o pulse.
- R9: After the last readback byte, cfg_cs_o drops, one more clock pulse is issued, and ok_o is set.
- R10: A length of 0 issues no data clock edges. A load goes straight to the done wait. A readback issues only its final pulse.
- R11: start_i is ignored while act_o is 1. An accepted start clears ok_o and abort_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, accepted only when idle |
| rb_mode_i | input | 1 | 0 = load, 1 = readback |
| len_i | input | LEN_W | Byte count for the command |
| src_data_i | input | 8 | Upstream load byte |
| src_valid_i | input | 1 | Upstream byte valid |
| src_ready_o | output | 1 | Block takes the byte this cycle |
| snk_data_o | output | 8 | Readback byte |
| snk_valid_o | output | 1 | One-cycle readback strobe |
| act_o | output | 1 | Command in progress |
| ok_o | output | 1 | Last command completed |
| abort_o | output | 1 | Last command timed out |
| cfg_prog_o | output | 1 | Program request to the device |
| cfg_init_i | input | 1 | Device ready for data |
| cfg_busy_i | input | 1 | Device busy |
| cfg_done_i | input | 1 | Device configuration done |
| cfg_cs_o | output | 1 | Device select |
| cfg_wr_o | output | 1 | Write direction (0 = read) |
| cfg_cclk_o | output | 1 | Configuration clock |
| cfg_dq_o | output | 8 | Data bus output value |
| cfg_dq_oe_o | output | 1 | Data bus output enable |
| cfg_dq_i | input | 8 | Data bus input value |

## Verification
The bench builds the block with HALF_CYC=3, TMO_CYC=400, CHECK_BUSY=1 and LEN_W=8. With a 400-cycle watchdog, all three timeouts can be reached in a short run: a ready flag stuck low, a busy flag stuck high, and a done flag that never comes. With a three-cycle phase, the exact low-phase width can be told apart from the one-cycle ready gap between bytes. A device model adds random busy stalls and delays DONE by a chosen number of clock edges, so stall repetition, byte ordering and the count of trailing pulses are all observed at the pins.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_RDY, S_REQ, S_LO, S_HI, S_STL_LO, S_STL_HI,
    S_END, S_DN_LO, S_DN_HI, S_RB_PARK, S_RB_LO, S_RB_HI, S_RB_ELO, S_RB_EHI
  } cfg_state_e;

  typedef enum logic [1:0] {G_NONE, G_RDY, G_STALL, G_DONE} wait_grp_e;

  // watchdog group of a state; a group change restarts the watchdog
  function automatic wait_grp_e grp_of(cfg_state_e s);
    unique case (s)
      S_RDY:                    return G_RDY;
      S_STL_LO, S_STL_HI:       return G_STALL;
      S_END, S_DN_LO, S_DN_HI:  return G_DONE;
      default:                  return G_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fpga_cfg_pace.sv
module fpga_cfg_pace #(
  parameter int HALF_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == PW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + PW'(1);
  end

  // a restarted phase never ticks at once unless the phase is one cycle
  p_tick_after_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && HALF_CYC > 1) |=> !tick_o)
    else $error("pace tick right after restart");

endmodule

// File: rtl/fpga_cfg_wdog.sv
module fpga_cfg_wdog #(
  parameter int TMO_CYC = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic exp_o
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [TW-1:0] cnt_q;

  assign exp_o = (cnt_q == TW'(TMO_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || clr_i)  cnt_q <= '0;
    else if (!exp_o)          cnt_q <= cnt_q + TW'(1);
  end

  p_exp_needs_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_o |-> $past(en_i))
    else $error("watchdog expired outside a wait");

endmodule

// File: rtl/fpga_cfg_bus.sv
module fpga_cfg_bus (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [7:0] din_i,
  input  logic       cap_i,
  input  logic [7:0] pin_i,
  output logic [7:0] dout_o,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o   <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      if (ld_i)  dout_o  <= din_i;
      if (cap_i) rdata_o <= pin_i;
      rvalid_o <= cap_i;
    end
  end

  p_rvalid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o)
    else $error("readback strobe longer than one cycle");

endmodule

// File: rtl/fpga_cfg_master.sv
module fpga_cfg_master
  import fpga_cfg_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int HALF_CYC   = 3,
  parameter int TMO_CYC    = 2500000,
  parameter int CHECK_BUSY = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rb_mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       src_data_i,
  input  logic             src_valid_i,
  output logic             src_ready_o,
  output logic [7:0]       snk_data_o,
  output logic             snk_valid_o,
  output logic             act_o,
  output logic             ok_o,
  output logic             abort_o,
  output logic             cfg_prog_o,
  input  logic             cfg_init_i,
  input  logic             cfg_busy_i,
  input  logic             cfg_done_i,
  output logic             cfg_cs_o,
  output logic             cfg_wr_o,
  output logic             cfg_cclk_o,
  output logic [7:0]       cfg_dq_o,
  output logic             cfg_dq_oe_o,
  input  logic [7:0]       cfg_dq_i
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam int LW = $clog2(HALF_CYC + 2);

  cfg_state_e       state_q, state_d;
  logic [LEN_W-1:0] rem_q;
  logic             ok_q, abort_q;
  logic             tick, wd_exp, busy_seen;
  logic             ld, cap, fin, abt, take;

  generate
    if (CHECK_BUSY != 0) begin : g_busy
      assign busy_seen = cfg_busy_i;
    end else begin : g_nobusy
      assign busy_seen = 1'b0;
    end
  endgenerate

  fpga_cfg_pace #(.HALF_CYC(HALF_CYC)) u_pace (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .tick_o (tick)
  );

  fpga_cfg_wdog #(.TMO_CYC(TMO_CYC)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (grp_of(state_q) != G_NONE),
    .clr_i  (grp_of(state_d) != grp_of(state_q)),
    .exp_o  (wd_exp)
  );

  fpga_cfg_bus u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld),
    .din_i    (src_data_i),
    .cap_i    (cap),
    .pin_i    (cfg_dq_i),
    .dout_o   (cfg_dq_o),
    .rdata_o  (snk_data_o),
    .rvalid_o (snk_valid_o)
  );

  assign take = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    ld  = 1'b0;
    cap = 1'b0;
    fin = 1'b0;
    abt = 1'b0;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = rb_mode_i ? S_RB_PARK : S_PROG;
      S_PROG:    if (tick) state_d = S_RDY;
      S_RDY: begin
        if (cfg_init_i && !cfg_busy_i) state_d = (rem_q == '0) ? S_END : S_REQ;
        else if (wd_exp) begin state_d = S_IDLE; abt = 1'b1; end
      end
      S_REQ: if (src_valid_i) begin state_d = S_LO; ld = 1'b1; end
      S_LO:  if (tick) state_d = S_HI;
      S_HI, S_STL_HI: begin
        if (state_q == S_STL_HI && wd_exp) begin state_d = S_IDLE; abt = 1'b1; end
        else if (tick) begin
          if (busy_seen)          state_d = S_STL_LO;
          else if (rem_q == '0)   state_d = S_END;
          else                    state_d = S_REQ;
        end
      end
      S_STL_LO: begin
        if (wd_exp) begin state_d = S_IDLE; abt = 1'b1; end
        else if (tick) state_d = S_STL_HI;
      end
      S_END, S_DN_HI: begin
        if (tick && cfg_done_i) begin state_d = S_IDLE; fin = 1'b1; end
        else if (wd_exp) begin state_d = S_IDLE; abt = 1'b1; end
        else if (tick) state_d = S_DN_LO;
      end
      S_DN_LO: begin
        if (wd_exp) begin state_d = S_IDLE; abt = 1'b1; end
        else if (tick) state_d = S_DN_HI;
      end
      S_RB_PARK: if (tick) state_d = (rem_q == '0) ? S_RB_ELO : S_RB_LO;
      S_RB_LO:   if (tick) state_d = S_RB_HI;
      S_RB_HI: if (tick) begin
        cap = 1'b1;
        state_d = (rem_q == ONE) ? S_RB_ELO : S_RB_LO;
      end
      S_RB_ELO:  if (tick) state_d = S_RB_EHI;
      S_RB_EHI:  if (tick) begin state_d = S_IDLE; fin = 1'b1; end
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      ok_q    <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take)            rem_q <= len_i;
      else if (ld || cap)  rem_q <= rem_q - ONE;
      if (take) begin
        ok_q    <= 1'b0;
        abort_q <= 1'b0;
      end else begin
        if (fin) ok_q    <= 1'b1;
        if (abt) abort_q <= 1'b1;
      end
    end
  end

  // pins decoded from the state register
  assign act_o       = (state_q != S_IDLE);
  assign ok_o        = ok_q;
  assign abort_o     = abort_q;
  assign src_ready_o = (state_q == S_REQ);
  assign cfg_prog_o  = (state_q == S_PROG);
  assign cfg_cs_o    = state_q inside {S_REQ, S_LO, S_HI, S_STL_LO, S_STL_HI,
                                       S_RB_PARK, S_RB_LO, S_RB_HI};
  assign cfg_wr_o    = state_q inside {S_REQ, S_LO, S_HI, S_STL_LO, S_STL_HI, S_END};
  assign cfg_cclk_o  = !(state_q inside {S_LO, S_STL_LO, S_DN_LO, S_RB_LO, S_RB_ELO});
  assign cfg_dq_oe_o = state_q inside {S_LO, S_HI, S_STL_LO, S_STL_HI};

  // low-phase length observer for the clock-rate check
  logic [LW-1:0] lo_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lo_run_q <= '0;
    else if (cfg_cclk_o)                  lo_run_q <= '0;
    else if (lo_run_q != LW'(HALF_CYC+1)) lo_run_q <= lo_run_q + LW'(1);
  end

  p_cclk_low_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cfg_cclk_o) && !abort_o) |-> (lo_run_q == LW'(HALF_CYC)))
    else $error("configuration clock low phase width");

  p_data_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cfg_cclk_o) && cfg_dq_oe_o) |-> $stable(cfg_dq_o))
    else $error("data changed at rising clock edge");

  p_ready_before_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cfg_cs_o) && cfg_wr_o) |-> ($past(cfg_init_i) && !$past(cfg_busy_i)))
    else $error("select raised before device ready");

  p_abort_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!cfg_cs_o && !cfg_wr_o && !cfg_dq_oe_o))
    else $error("pins active while abort latched");

  p_cs_before_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cfg_wr_o) && !abort_o) |-> $past(!cfg_cs_o))
    else $error("write released before select");

  p_status_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && abort_o))
    else $error("ok and abort both set");

  p_rb_no_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_valid_o |-> (!cfg_wr_o && !cfg_dq_oe_o))
    else $error("bus driven during readback");

endmodule

// File: tb/fpga_cfg_master_bench.sv
module fpga_cfg_master_bench;
  localparam int HALF = 3;
  localparam int TMO  = 400;
  localparam int LW   = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          start_i = 0, rb_mode_i = 0;
  logic [LW-1:0] len_i = '0;
  logic [7:0]    src_data_i = '0;
  logic          src_valid_i = 0;
  logic          src_ready_o, snk_valid_o, act_o, ok_o, abort_o;
  logic [7:0]    snk_data_o, cfg_dq_o;
  logic          cfg_prog_o, cfg_cs_o, cfg_wr_o, cfg_cclk_o, cfg_dq_oe_o;
  logic          init_i = 1'b1, busy_i = 1'b0, done_i = 1'b0;
  logic [7:0]    dq_i = '0;

  fpga_cfg_master #(.LEN_W(LW), .HALF_CYC(HALF), .TMO_CYC(TMO), .CHECK_BUSY(1))
  u_fpga_cfg_master (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rb_mode_i(rb_mode_i),
    .len_i(len_i), .src_data_i(src_data_i), .src_valid_i(src_valid_i),
    .src_ready_o(src_ready_o), .snk_data_o(snk_data_o), .snk_valid_o(snk_valid_o),
    .act_o(act_o), .ok_o(ok_o), .abort_o(abort_o), .cfg_prog_o(cfg_prog_o),
    .cfg_init_i(init_i), .cfg_busy_i(busy_i), .cfg_done_i(done_i),
    .cfg_cs_o(cfg_cs_o), .cfg_wr_o(cfg_wr_o), .cfg_cclk_o(cfg_cclk_o),
    .cfg_dq_o(cfg_dq_o), .cfg_dq_oe_o(cfg_dq_oe_o), .cfg_dq_i(dq_i)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] sent [64];
  logic [7:0] got  [64];
  logic [7:0] rdg  [64];
  int n_got, n_rd, wr_edges, nocs_edges, rb_edges, total_stall, stall_left;
  int stall_max = 0, done_target = 0, act_cyc = 0;
  bit init_stuck = 0, busy_hold = 0, quit = 0;
  int lo_err = 0, prog_err = 0, early_err = 0, r3_err = 0, seq_err = 0;
  int hold_err = 0, rb_oe_err = 0, init_cnt = 0;

  function automatic logic [7:0] pat(int k);
    return 8'((k * 29 + 7) ^ 8'h5A);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device ready flag
  always @(posedge clk) begin
    if (cfg_prog_o) begin
      init_i <= 1'b0; init_cnt <= 0;
    end else if (!init_i && !init_stuck) begin
      init_cnt <= init_cnt + 1;
      if (init_cnt == 4) init_i <= 1'b1;
    end
  end

  // device reaction to configuration clock rising edges
  always @(posedge cfg_cclk_o) begin
    if (rst_ni) begin
      if (cfg_cs_o && cfg_wr_o) begin
        wr_edges++;
        if (busy_i) begin
          if (n_got > 0 && cfg_dq_o != got[n_got-1]) hold_err++;
          stall_left--;
          if (stall_left <= 0) busy_i = 1'b0;
        end else begin
          if (n_got < 64) got[n_got] = cfg_dq_o;
          n_got++;
          stall_left = busy_hold ? 1000000 : int'($urandom % (stall_max + 1));
          if (stall_left > 0) begin
            busy_i = 1'b1;
            total_stall += stall_left;
          end
        end
      end else if (cfg_cs_o && !cfg_wr_o) begin
        rb_edges++;
        dq_i = pat(rb_edges);
      end else if (!cfg_cs_o && !cfg_wr_o && act_o) begin
        nocs_edges++;
        if (done_target >= 0 && nocs_edges >= done_target) done_i = 1'b1;
      end
    end
  end

  // pin monitors sampled away from the active edge
  logic cclk_p = 1, prog_p = 0, cs_p = 0, wr_p = 0, oe_p = 0;
  int lo_len = 0, prog_len = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!cfg_cclk_o) lo_len++;
      else begin
        if (!cclk_p && !abort_o && lo_len != HALF) lo_err++;
        lo_len = 0;
      end
      if (cfg_prog_o) prog_len++;
      else begin
        if (prog_p && prog_len != HALF) prog_err++;
        prog_len = 0;
      end
      if (cfg_cs_o && !cs_p && cfg_wr_o && !init_i) early_err++;
      if (cfg_dq_oe_o && !oe_p && !(cs_p && wr_p && cclk_p)) r3_err++;
      if (!cfg_cs_o && cs_p && wr_p && !abort_o && !(cfg_wr_o && !cfg_dq_oe_o)) seq_err++;
      if (cfg_cs_o && !cfg_wr_o && cfg_dq_oe_o) rb_oe_err++;
      if (snk_valid_o) begin
        if (n_rd < 64) rdg[n_rd] = snk_data_o;
        n_rd++;
      end
      if (act_o) act_cyc++;
      cclk_p = cfg_cclk_o; prog_p = cfg_prog_o; cs_p = cfg_cs_o;
      wr_p = cfg_wr_o; oe_p = cfg_dq_oe_o;
    end
  end

  task automatic prep(input int smax, input int dtgt);
    n_got = 0; n_rd = 0; wr_edges = 0; nocs_edges = 0; rb_edges = 0;
    total_stall = 0; stall_left = 0; busy_i = 1'b0; act_cyc = 0;
    stall_max = smax; done_target = dtgt; done_i = (dtgt == 0);
    quit = 0;
  endtask

  task automatic start_pulse(input bit rb, input int n);
    @(negedge clk);
    start_i = 1; rb_mode_i = rb; len_i = LW'(n);
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (act_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic feed(input int n, input int gap_max);
    for (int i = 0; i < n; i++) begin
      if (quit) break;
      repeat (int'($urandom % (gap_max + 1))) @(negedge clk);
      src_valid_i = 1; src_data_i = sent[i];
      while (!src_ready_o && !quit) @(negedge clk);
      @(negedge clk);
      src_valid_i = 0;
    end
  endtask

  task automatic run_load(input int n, input int gap_max);
    for (int i = 0; i < n; i++) sent[i] = 8'($urandom);
    fork
      feed(n, gap_max);
      begin start_pulse(0, n); wait_idle(); quit = 1; end
    join
  endtask

  task automatic cmp_bytes(input string req, input int n);
    int mism = 0;
    for (int i = 0; i < n; i++) if (got[i] != sent[i]) mism++;
    chk(req, mism, 0);
  endtask

  task automatic cmp_rb(input string req, input int n);
    int mism = 0;
    for (int i = 0; i < n; i++) if (rdg[i] != pat(i + 1)) mism++;
    chk(req, mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs", int'(cfg_cs_o), 0);
    chk("R1 wr", int'(cfg_wr_o), 0);
    chk("R1 oe/prog", int'(cfg_dq_oe_o | cfg_prog_o), 0);
    chk("R1 cclk", int'(cfg_cclk_o), 1);
    chk("R1 status", int'({act_o, ok_o, abort_o}), 0);

    // directed load, no stalls
    prep(0, 3);
    run_load(5, 0);
    chk("R4 byte count", n_got, 5);
    cmp_bytes("R4 byte order", 5);
    chk("R4 edges", wr_edges, 5);
    chk("R6 done edges", nocs_edges, 3);
    chk("R6 ok", int'({ok_o, abort_o}), 2);
    chk("R2 prog width", prog_err, 0);
    chk("R2 ready gate", early_err, 0);
    chk("R3 park before data", r3_err, 0);

    // stalls with upstream gaps
    prep(3, 1);
    run_load(12, 3);
    cmp_bytes("R5 bytes under stall", 12);
    chk("R5 stall edges", wr_edges, 12 + total_stall);
    chk("R5 byte held", hold_err, 0);
    chk("R6 ok after stall", int'(ok_o), 1);

    // random loads
    for (int it = 0; it < 6; it++) begin
      int n = 1 + int'($urandom % 10);
      int d = int'($urandom % 5);
      prep(int'($urandom % 3), d);
      run_load(n, int'($urandom % 3));
      cmp_bytes("R4 random bytes", n);
      chk("R5 random edges", wr_edges, n + total_stall);
      chk("R6 random done edges", nocs_edges, d);
      chk("R6 random ok", int'(ok_o), 1);
    end

    // zero-length load
    prep(0, 0);
    run_load(0, 0);
    chk("R10 load no edges", wr_edges + n_got, 0);
    chk("R10 load no done pulses", nocs_edges, 0);
    chk("R10 load ok", int'(ok_o), 1);

    // readback
    prep(0, -1);
    start_pulse(1, 6);
    wait_idle();
    chk("R8 rb count", n_rd, 6);
    cmp_rb("R8 rb data", 6);
    chk("R8 rb edges", rb_edges, 6);
    chk("R8 bus released", rb_oe_err, 0);
    chk("R9 trailing pulse", nocs_edges, 1);
    chk("R9 ok", int'(ok_o), 1);

    // zero-length readback
    prep(0, -1);
    start_pulse(1, 0);
    wait_idle();
    chk("R10 rb none", n_rd + rb_edges, 0);
    chk("R10 rb final pulse", nocs_edges, 1);

    // start ignored while active
    prep(0, -1);
    start_pulse(1, 4);
    repeat (5) @(negedge clk);
    start_i = 1; rb_mode_i = 0; len_i = 8'd9;
    @(negedge clk);
    start_i = 0;
    wait_idle();
    chk("R11 rb unaffected", n_rd, 4);
    chk("R11 no load", n_got + wr_edges, 0);
    chk("R11 ok", int'(ok_o), 1);

    // ready timeout
    prep(0, 1);
    init_stuck = 1;
    run_load(2, 0);
    init_stuck = 0;
    chk("R7 init abort", int'({ok_o, abort_o}), 1);
    chk("R7 init quiet", int'({cfg_cs_o, cfg_wr_o, cfg_dq_oe_o, act_o}), 0);
    chk("R7 init wait length", int'(act_cyc >= TMO && act_cyc <= TMO + HALF + 4), 1);

    // done timeout
    prep(0, -1);
    run_load(3, 0);
    chk("R7 done abort", int'({ok_o, abort_o}), 1);
    chk("R7 done bytes", n_got, 3);

    // busy stuck
    prep(0, -1);
    busy_hold = 1;
    run_load(4, 0);
    busy_hold = 0;
    chk("R7 busy abort", int'({ok_o, abort_o}), 1);
    chk("R7 busy quiet", int'({cfg_cs_o, cfg_wr_o, cfg_dq_oe_o}), 0);

    // new start clears abort
    prep(0, 1);
    for (int i = 0; i < 2; i++) sent[i] = 8'($urandom);
    fork
      feed(2, 0);
      begin
        start_pulse(0, 2);
        chk("R11 status cleared", int'({ok_o, abort_o}), 0);
        wait_idle();
        quit = 1;
      end
    join
    cmp_bytes("R4 after abort", 2);
    chk("R11 ok after clear", int'(ok_o), 1);
    chk("R4 low width", lo_err, 0);
    chk("R6 cs then wr", seq_err, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule